// File: doc/BRIEF.md
# Processor Exception Entry Controller

This block computes the state changes a small 32-bit RISC core makes when it takes an exception. It also produces the core's power-on state. A request carries a 3-bit exception code, and the block samples the current status word and the current program counter. A static configuration pin selects between a 32-bit architecture and a 26-bit one. In the 26-bit architecture the flags, the interrupt masks and the mode bits travel inside the program-counter word.

On the clock edge that accepts a request, the block registers five results: the new status word, the saved-status bank to write together with the value for it, the link value, and the new program counter, which points at the exception vector. A one-cycle done strobe marks the cycle in which these results are valid. The surrounding core uses them to update its register file.

Top module: `exc_entry_ctrl`

## Requirements
- R1: While `rst` is high at a clock edge, the block loads its reset state. In the 32-bit configuration, `new_psr` is 0x000000D3 and `new_pc` is 0. In the 26-bit configuration, `new_psr` is 0x000000C3 and `new_pc` is 0x0C000003. In both configurations `done`, `spsr_we`, `lr_out`, `spsr_bank` and `spsr_data` are zero.
- R2: A request with `req_valid` high at a clock edge makes every result, `done` and `spsr_we` valid right after that edge. Without a request, `done` and `spsr_we` drop to 0 at the next edge while `new_psr`, `new_pc` and `lr_out` keep their values.
- R3: Exception code c (0 reset, 1 undefined instruction, 2 software interrupt, 3 prefetch abort, 4 data abort, 5 address exception, 6 IRQ, 7 FIQ) has the vector address 4*c. When the new mode is a 32-bit mode (bit 4 set), `new_pc` equals that vector.
- R4: `spsr_bank` takes one of five values: 0 supervisor, 1 abort, 2 undefined, 3 IRQ, 4 FIQ. Reset, software interrupt and address exception select bank 0. IRQ selects bank 3 and FIQ selects bank 4. Undefined instruction selects bank 2, and either abort selects bank 1, but only in the 32-bit configuration. In the 26-bit configuration those three select bank 0.
- R5: The new mode (bits 4:0 of `new_psr`) depends on the configuration. In the 32-bit configuration, reset and software interrupt give 5'b10011, undefined gives 5'b11011, the aborts give 5'b10111, IRQ gives 5'b10010 and FIQ gives 5'b10001. In the 26-bit configuration, IRQ gives 5'b00010, FIQ gives 5'b00001 and every other code gives 5'b00011.
- R6: Reset and FIQ entry set both bit 7 (IRQ mask) and bit 6 (FIQ mask). Every other entry sets bit 7 and copies bit 6 from `cur_psr`.
- R7: On every entry, `spsr_data` equals the `cur_psr` that was sampled with the request.
- R8: The captured return value depends on the configuration. In the 32-bit configuration it is `cur_pc`. In the 26-bit configuration it is built as {cur_psr[31:28], cur_psr[7], cur_psr[6], cur_pc[25:2], cur_psr[1:0]}.
- R9: `lr_out` is the captured value minus 4, modulo 2^32, for every code except reset. For reset it is the captured value unchanged.
- R10: When the new mode is a 26-bit mode (bit 4 clear), `new_pc` is {new_psr[31:28], new_psr[7], new_psr[6], vector[25:2], new_psr[1:0]}.
- R11: The address exception always enters mode 5'b00011 with bit 7 set, in both configurations.
- R12: Bits 31:8 and bit 5 of `new_psr` are copied from `cur_psr`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_32 | input | 1 | 1 selects the 32-bit architecture, 0 selects the 26-bit one |
| req_valid | input | 1 | Exception request |
| req_code | input | 3 | Exception code |
| cur_psr | input | 32 | Current status word |
| cur_pc | input | 32 | Current program counter |
| new_psr | output | 32 | Status word after entry |
| new_pc | output | 32 | Program counter after entry |
| lr_out | output | 32 | Link register value |
| spsr_we | output | 1 | Saved-status write enable |
| spsr_bank | output | 3 | Saved-status bank index |
| spsr_data | output | 32 | Value for the saved-status bank |
| done | output | 1 | Entry strobe |

## Verification
Every result comes out of a single register stage. The outputs of an entry are therefore due just after the edge that samples `req_valid`, and they must clear or hold one edge later. Reset values are due after the first edge with `rst` high. The bench drives its inputs on falling edges and reads all outputs on the following falling edge. For a request, it lowers `req_valid` before that read, so the value read is the one the entry edge produced. It then reads once more, a cycle later, to confirm that `done` and `spsr_we` have dropped while the status, PC and link values are held.

// File: rtl/exc_entry_pkg.sv
package exc_entry_pkg;
    localparam int XLEN      = 32;
    localparam int MODE_W    = 5;
    localparam int CODE_W    = 3;
    localparam int BANK_W    = 3;
    localparam int VEC_SHIFT = 2;
    localparam int BIT_I     = 7;
    localparam int BIT_F     = 6;
    localparam int BIT_T     = 5;
    localparam logic [XLEN-1:0] RET_ADJ = XLEN'(4);

    typedef enum logic [CODE_W-1:0] {
        EXC_RESET = 3'd0,
        EXC_UNDEF = 3'd1,
        EXC_SWI   = 3'd2,
        EXC_PABT  = 3'd3,
        EXC_DABT  = 3'd4,
        EXC_ADDR  = 3'd5,
        EXC_IRQ   = 3'd6,
        EXC_FIQ   = 3'd7
    } exc_code_e;

    typedef enum logic [BANK_W-1:0] {
        BANK_SVC = 3'd0,
        BANK_ABT = 3'd1,
        BANK_UND = 3'd2,
        BANK_IRQ = 3'd3,
        BANK_FIQ = 3'd4
    } bank_e;

    localparam logic [MODE_W-1:0] M32_FIQ = 5'b10001;
    localparam logic [MODE_W-1:0] M32_IRQ = 5'b10010;
    localparam logic [MODE_W-1:0] M32_SVC = 5'b10011;
    localparam logic [MODE_W-1:0] M32_ABT = 5'b10111;
    localparam logic [MODE_W-1:0] M32_UND = 5'b11011;
    localparam logic [MODE_W-1:0] M26_FIQ = 5'b00001;
    localparam logic [MODE_W-1:0] M26_IRQ = 5'b00010;
    localparam logic [MODE_W-1:0] M26_SVC = 5'b00011;

    typedef struct packed {
        bank_e             bank;
        logic [MODE_W-1:0] mode;
        logic              mask_fiq;
    } route_t;

    function automatic logic [XLEN-1:0] vec_addr(input logic [CODE_W-1:0] code);
        return XLEN'(code) << VEC_SHIFT;
    endfunction

    // Combined 26-bit word: flags, masks, word address, low mode bits
    function automatic logic [XLEN-1:0] pack26(input logic [XLEN-1:0] psr,
                                               input logic [XLEN-1:0] addr);
        return {psr[31:28], psr[BIT_I], psr[BIT_F], addr[25:2], psr[1:0]};
    endfunction

    function automatic logic [XLEN-1:0] mode_is32_pc(input logic [XLEN-1:0] psr,
                                                     input logic [XLEN-1:0] addr);
        return psr[4] ? addr : pack26(psr, addr);
    endfunction
endpackage

// File: rtl/exc_route.sv
module exc_route
    import exc_entry_pkg::*;
(
    input  logic [CODE_W-1:0] code,
    input  logic              cfg_32,
    output route_t            route
);
    always_comb begin
        route.bank     = BANK_SVC;
        route.mode     = cfg_32 ? M32_SVC : M26_SVC;
        route.mask_fiq = 1'b0;
        unique case (exc_code_e'(code))
            EXC_RESET: route.mask_fiq = 1'b1;
            EXC_SWI:   ;
            EXC_UNDEF: if (cfg_32) begin
                route.bank = BANK_UND;
                route.mode = M32_UND;
            end
            EXC_PABT, EXC_DABT: if (cfg_32) begin
                route.bank = BANK_ABT;
                route.mode = M32_ABT;
            end
            EXC_ADDR:  route.mode = M26_SVC;
            EXC_IRQ: begin
                route.bank = BANK_IRQ;
                route.mode = cfg_32 ? M32_IRQ : M26_IRQ;
            end
            EXC_FIQ: begin
                route.bank     = BANK_FIQ;
                route.mode     = cfg_32 ? M32_FIQ : M26_FIQ;
                route.mask_fiq = 1'b1;
            end
            default: ;
        endcase
    end
endmodule

// File: rtl/exc_retaddr.sv
module exc_retaddr
    import exc_entry_pkg::*;
(
    input  logic [CODE_W-1:0] code,
    input  logic              cfg_32,
    input  logic [XLEN-1:0]   psr,
    input  logic [XLEN-1:0]   pc,
    output logic [XLEN-1:0]   link
);
    logic [XLEN-1:0] captured;

    always_comb begin
        captured = cfg_32 ? pc : pack26(psr, pc);
        link     = (exc_code_e'(code) == EXC_RESET) ? captured : captured - RET_ADJ;
    end
endmodule

// File: rtl/exc_psr_build.sv
module exc_psr_build
    import exc_entry_pkg::*;
(
    input  logic [XLEN-1:0]   psr_in,
    input  route_t            route,
    input  logic [CODE_W-1:0] code,
    output logic [XLEN-1:0]   psr_out,
    output logic [XLEN-1:0]   pc_out
);
    always_comb begin
        psr_out             = psr_in;
        psr_out[BIT_I]      = 1'b1;
        psr_out[BIT_F]      = psr_in[BIT_F] | route.mask_fiq;
        psr_out[MODE_W-1:0] = route.mode;
        pc_out              = mode_is32_pc(psr_out, vec_addr(code));
    end
endmodule

// File: rtl/exc_entry_ctrl.sv
module exc_entry_ctrl
    import exc_entry_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              cfg_32,
    input  logic              req_valid,
    input  logic [2:0]        req_code,
    input  logic [31:0]       cur_psr,
    input  logic [31:0]       cur_pc,
    output logic [31:0]       new_psr,
    output logic [31:0]       new_pc,
    output logic [31:0]       lr_out,
    output logic              spsr_we,
    output logic [2:0]        spsr_bank,
    output logic [31:0]       spsr_data,
    output logic              done
);
    route_t          route;
    logic [XLEN-1:0] link_d;
    logic [XLEN-1:0] psr_d;
    logic [XLEN-1:0] pc_d;
    logic [XLEN-1:0] rst_psr;
    logic [XLEN-1:0] rst_pc;

    exc_route u_route (
        .code   (req_code),
        .cfg_32 (cfg_32),
        .route  (route)
    );

    exc_retaddr u_ret (
        .code   (req_code),
        .cfg_32 (cfg_32),
        .psr    (cur_psr),
        .pc     (cur_pc),
        .link   (link_d)
    );

    exc_psr_build u_psr (
        .psr_in  (cur_psr),
        .route   (route),
        .code    (req_code),
        .psr_out (psr_d),
        .pc_out  (pc_d)
    );

    always_comb begin
        rst_psr             = '0;
        rst_psr[BIT_I]      = 1'b1;
        rst_psr[BIT_F]      = 1'b1;
        rst_psr[MODE_W-1:0] = cfg_32 ? M32_SVC : M26_SVC;
        rst_pc              = mode_is32_pc(rst_psr, '0);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            new_psr   <= rst_psr;
            new_pc    <= rst_pc;
            lr_out    <= '0;
            spsr_we   <= 1'b0;
            spsr_bank <= '0;
            spsr_data <= '0;
            done      <= 1'b0;
        end else begin
            spsr_we <= req_valid;
            done    <= req_valid;
            if (req_valid) begin
                new_psr   <= psr_d;
                new_pc    <= pc_d;
                lr_out    <= link_d;
                spsr_bank <= route.bank;
                spsr_data <= cur_psr;
            end
        end
    end
endmodule

// File: rtl/exc_entry_chk.sv
module exc_entry_chk (
    input logic        clk,
    input logic        rst,
    input logic        cfg_32,
    input logic        req_valid,
    input logic [2:0]  req_code,
    input logic [31:0] cur_psr,
    input logic [31:0] cur_pc,
    input logic [31:0] new_psr,
    input logic [31:0] new_pc,
    input logic [31:0] lr_out,
    input logic        spsr_we,
    input logic [2:0]  spsr_bank,
    input logic [31:0] spsr_data,
    input logic        done
);
    assert_done_follows_R2: assert property (@(posedge clk) disable iff (rst)
        req_valid |=> (done && spsr_we));

    assert_hold_idle_R2: assert property (@(posedge clk) disable iff (rst)
        !req_valid |=> (!done && $stable(new_pc) && $stable(lr_out)));

    assert_irq_mask_R6: assert property (@(posedge clk) disable iff (rst)
        done |-> new_psr[7]);

    assert_fiq_bank_masks_R6: assert property (@(posedge clk) disable iff (rst)
        (done && spsr_bank == 3'd4) |-> (new_psr[6] && new_psr[7]));

    assert_vector_range_R3: assert property (@(posedge clk) disable iff (rst)
        (done && new_psr[4]) |-> (new_pc[1:0] == 2'b00 && new_pc[31:5] == '0));

    assert_link32_R9: assert property (@(posedge clk) disable iff (rst)
        (req_valid && cfg_32 && req_code != 3'd0) |=> (lr_out == $past(cur_pc) - 32'd4));

    assert_saved_R7: assert property (@(posedge clk) disable iff (rst)
        req_valid |=> (spsr_data == $past(cur_psr)));
endmodule

bind exc_entry_ctrl exc_entry_chk u_chk (
    .clk       (clk),
    .rst       (rst),
    .cfg_32    (cfg_32),
    .req_valid (req_valid),
    .req_code  (req_code),
    .cur_psr   (cur_psr),
    .cur_pc    (cur_pc),
    .new_psr   (new_psr),
    .new_pc    (new_pc),
    .lr_out    (lr_out),
    .spsr_we   (spsr_we),
    .spsr_bank (spsr_bank),
    .spsr_data (spsr_data),
    .done      (done)
);

// File: tb/tb_exc_entry_ctrl.sv
`timescale 1ns/1ps
module tb_exc_entry_ctrl;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        cfg_32 = 1'b1;
    logic        req_valid = 1'b0;
    logic [2:0]  req_code = '0;
    logic [31:0] cur_psr = '0;
    logic [31:0] cur_pc = '0;
    logic [31:0] new_psr, new_pc, lr_out, spsr_data;
    logic        spsr_we, done;
    logic [2:0]  spsr_bank;

    int checks = 0;
    int fails  = 0;
    bit finished = 0;

    always #2 clk = ~clk;

    exc_entry_ctrl dut (
        .clk(clk), .rst(rst), .cfg_32(cfg_32), .req_valid(req_valid),
        .req_code(req_code), .cur_psr(cur_psr), .cur_pc(cur_pc),
        .new_psr(new_psr), .new_pc(new_pc), .lr_out(lr_out),
        .spsr_we(spsr_we), .spsr_bank(spsr_bank), .spsr_data(spsr_data),
        .done(done)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic do_reset(input logic c32);
        @(negedge clk);
        cfg_32 = c32; rst = 1'b1; req_valid = 1'b0;
        @(negedge clk);
        rst = 1'b0;
        chk("R1 psr", new_psr, c32 ? 32'h0000_00D3 : 32'h0000_00C3);
        chk("R1 pc",  new_pc,  c32 ? 32'h0 : 32'h0C00_0003);
        chk("R1 done/we", {30'd0, done, spsr_we}, 32'd0);
        chk("R1 lr", lr_out, 32'd0);
        chk("R1 bank/data", {29'd0, spsr_bank} | spsr_data, 32'd0);
    endtask

    // Independent expectation model
    task automatic expect_entry(input logic [2:0] code, input logic c32,
                                input logic [31:0] psr, input logic [31:0] pc,
                                output logic [31:0] e_psr, output logic [31:0] e_pc,
                                output logic [31:0] e_lr, output logic [2:0] e_bank);
        logic [4:0]  m;
        logic        setf;
        logic [31:0] cap, vec;
        setf = (code == 3'd0) || (code == 3'd7);
        case (code)
            3'd0, 3'd2: begin m = c32 ? 5'b10011 : 5'b00011; e_bank = 3'd0; end
            3'd1: begin m = c32 ? 5'b11011 : 5'b00011; e_bank = c32 ? 3'd2 : 3'd0; end
            3'd3, 3'd4: begin m = c32 ? 5'b10111 : 5'b00011; e_bank = c32 ? 3'd1 : 3'd0; end
            3'd5: begin m = 5'b00011; e_bank = 3'd0; end
            3'd6: begin m = c32 ? 5'b10010 : 5'b00010; e_bank = 3'd3; end
            default: begin m = c32 ? 5'b10001 : 5'b00001; e_bank = 3'd4; end
        endcase
        e_psr = {psr[31:8], 1'b1, psr[6] | setf, psr[5], m};
        cap   = c32 ? pc : {psr[31:28], psr[7], psr[6], pc[25:2], psr[1:0]};
        e_lr  = (code == 3'd0) ? cap : cap - 32'd4;
        vec   = {27'd0, code, 2'b00};
        e_pc  = m[4] ? vec : {e_psr[31:28], e_psr[7], e_psr[6], vec[25:2], e_psr[1:0]};
    endtask

    task automatic do_entry(input string tag, input logic [2:0] code, input logic c32,
                            input logic [31:0] psr, input logic [31:0] pc);
        logic [31:0] e_psr, e_pc, e_lr;
        logic [2:0]  e_bank;
        expect_entry(code, c32, psr, pc, e_psr, e_pc, e_lr, e_bank);
        @(negedge clk);
        cfg_32 = c32; req_code = code; cur_psr = psr; cur_pc = pc; req_valid = 1'b1;
        @(negedge clk);
        req_valid = 1'b0; cur_psr = ~psr; cur_pc = ~pc;
        chk({tag, " R2 done"}, {31'd0, done}, 32'd1);
        chk({tag, " R2 we"}, {31'd0, spsr_we}, 32'd1);
        chk({tag, " R4 bank"}, {29'd0, spsr_bank}, {29'd0, e_bank});
        chk({tag, " R5 R6 R12 psr"}, new_psr, e_psr);
        chk({tag, " R3 R10 pc"}, new_pc, e_pc);
        chk({tag, " R8 R9 lr"}, lr_out, e_lr);
        chk({tag, " R7 spsr"}, spsr_data, psr);
        @(negedge clk);
        chk({tag, " R2 done drop"}, {30'd0, done, spsr_we}, 32'd0);
        chk({tag, " R2 hold psr"}, new_psr, e_psr);
        chk({tag, " R2 hold pc"}, new_pc, e_pc);
        chk({tag, " R2 hold lr"}, lr_out, e_lr);
    endtask

    task automatic sweep_32;
        for (int c = 0; c < 8; c++)
            do_entry("cfg32", 3'(c), 1'b1, 32'hA000_0010 | 32'(c << 8), 32'h0000_1000 + 32'(c * 16));
    endtask

    task automatic sweep_26;
        for (int c = 0; c < 8; c++)
            do_entry("cfg26", 3'(c), 1'b0, 32'h5000_0042 ^ 32'(c << 12), 32'h0012_3450 + 32'(c * 4));
    endtask

    task automatic corner_cases;
        // R11 address exception in 32-bit config, F mask kept clear
        do_entry("R11 addr32", 3'd5, 1'b1, 32'hF000_0013, 32'h0000_0800);
        chk("R11 mode", {27'd0, new_psr[4:0]}, 32'h3);
        chk("R11 F kept", {31'd0, new_psr[6]}, 32'd0);
        // R9 link wraps at zero
        do_entry("R9 wrap", 3'd6, 1'b1, 32'h0000_0010, 32'h0000_0000);
        // R8 26-bit packing with high pc bits discarded
        do_entry("R8 pack", 3'd2, 1'b0, 32'h9000_00C2, 32'hFC00_0004);
        // R6 FIQ mask from current word retained
        do_entry("R6 keepF", 3'd6, 1'b1, 32'h0000_0050, 32'h0000_0100);
    endtask

    task automatic back_to_back;
        logic [31:0] e_psr, e_pc, e_lr;
        logic [2:0]  e_bank;
        @(negedge clk);
        cfg_32 = 1'b1; req_valid = 1'b1; req_code = 3'd1; cur_psr = 32'h10; cur_pc = 32'h200;
        @(negedge clk);
        req_code = 3'd7; cur_psr = 32'h13; cur_pc = 32'h300;
        chk("R2 b2b first done", {31'd0, done}, 32'd1);
        @(negedge clk);
        req_valid = 1'b0;
        expect_entry(3'd7, 1'b1, 32'h13, 32'h300, e_psr, e_pc, e_lr, e_bank);
        chk("R2 b2b second done", {31'd0, done}, 32'd1);
        chk("R4 b2b bank", {29'd0, spsr_bank}, {29'd0, e_bank});
        chk("R9 b2b lr", lr_out, e_lr);
    endtask

    initial begin
        fork
            begin
                do_reset(1'b1);
                sweep_32();
                do_reset(1'b0);
                sweep_26();
                do_reset(1'b1);
                corner_cases();
                back_to_back();
                finished = 1;
            end
            begin
                repeat (20000) @(posedge clk);
                if (!finished) begin
                    checks++; fails++;
                    $display("FAIL watchdog actual=hung expected=done");
                end
            end
        join_any
        disable fork;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule